// File: doc/BRIEF.md
# Single-Cycle MIPS Subset Processor Core

This block is a non-pipelined 32-bit processor core for a fixed eleven-instruction MIPS subset. Each clock edge completes one whole instruction: fetch, decode, register read, ALU, optional memory access and write-back. The core covers register-register add, sub, set-less-than and the two logical shifts. It also covers add-immediate, word load and store, and the two compare-and-branch forms. A special all-zero word with function code 0x0C is taken as halt.

Program and data share one word-organised 1 KB memory. Bytes 0 to 511 hold data words and bytes 512 to 1023 hold program text. Execution starts at byte address 0x200. The memory is filled through a load port while the core is held in reset, and that port stays idle during execution. A reset of the core clears its registers and its cycle counter but leaves memory as it is.

Once halt is decoded, the core raises a sticky done flag and freezes all of its state. The current PC and a count of executed instructions are visible every cycle. A combinational debug port reads any register.

Top module: `mips_sc_core`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises: pc = 0x200, cycle_cnt = 0, done = 0, and every register reads 0 on the debug port.
- R2: With opcode 0, funct 0x20 (add) writes rs+rt to rd and funct 0x22 (sub) writes rs-rt to rd; both wrap modulo 2^32 and never trap.
- R3: With opcode 0, funct 0x00 (sll) writes rt shifted left by shamt[10:6] to rd and funct 0x02 (srl) writes rt shifted right logically by shamt to rd.
- R4: With opcode 0, funct 0x2A (slt) writes 1 to rd when rs < rt as signed 32-bit values, otherwise 0.
- R5: Opcode 0x08 (addi) writes rs + sign-extended imm[15:0] to rt, wrapping.
- R6: Opcode 0x23 (lw) loads, and opcode 0x2B (sw) stores, the word at byte address rs + sign-extended imm; the word index is address bits [9:2].
- R7: Opcode 0x04 (beq) and opcode 0x05 (bne) go to PC+4+sext(imm)*4 when taken (rs equal, resp. not equal, to rt), and to PC+4 otherwise; forward and backward offsets both work.
- R8: Register 0 always reads 0; writes to it are discarded.
- R9: The word 0x0000000C (halt) sets done; from then on done stays 1, pc holds the halt word's address, and no later word executes.
- R10: cycle_cnt rises by one on each clock that executes a word, the halt word included, and stops once done is 1.
- R11: Memory contents survive a core reset; a word stored before the reset can be loaded after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous core reset |
| ld_we | input | 1 | Memory load-port write enable (idle during execution) |
| ld_addr | input | 8 | Memory load-port word index (byte address / 4) |
| ld_data | input | 32 | Memory load-port write data |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Value of the selected register |
| pc | output | 32 | Byte address of the word being executed |
| cycle_cnt | output | 32 | Count of executed words since reset |
| done | output | 1 | High once halt has executed |

## Verification
A wrong decode or ALU path shows as a wrong register value on the debug port right after the instruction's clock edge. The bench reads those values out once the program halts. A wrong branch decision or target shows as a different count of executed words and a different frozen PC at halt, because a skipped or repeated word changes both. A missed halt or a leaking write enable shows within a few cycles after done, as a PC that moves, a counter that keeps counting, or a register written by the word after halt.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_BNE   = 6'h05;

   localparam logic [5:0] FN_ADD   = 6'h20;
   localparam logic [5:0] FN_SUB   = 6'h22;
   localparam logic [5:0] FN_SLL   = 6'h00;
   localparam logic [5:0] FN_SRL   = 6'h02;
   localparam logic [5:0] FN_SLT   = 6'h2A;

   localparam logic [31:0] HALT_WORD = 32'h0000_000C;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_SLL,
      ALU_SRL,
      ALU_SLT
   } alu_op_e;

   typedef struct packed {
      alu_op_e alu_op;
      logic    reg_we;
      logic    dst_rd;
      logic    b_imm;
      logic    mem_rd;
      logic    mem_wr;
      logic    br_eq;
      logic    br_ne;
      logic    halt;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [31:0]   instr,
   output ctrl_t         ctrl,
   output logic [4:0]    rs,
   output logic [4:0]    rt,
   output logic [4:0]    rd,
   output logic [4:0]    shamt,
   output logic [DW-1:0] imm_sx
);

   logic [5:0] opcode;
   logic [5:0] funct;

   assign opcode = instr[31:26];
   assign rs     = instr[25:21];
   assign rt     = instr[20:16];
   assign rd     = instr[15:11];
   assign shamt  = instr[10:6];
   assign funct  = instr[5:0];
   assign imm_sx = {{(DW-16){instr[15]}}, instr[15:0]};

   always_comb begin
      ctrl        = '0;
      ctrl.alu_op = ALU_ADD;
      if (instr == HALT_WORD) begin
         ctrl.halt = 1'b1;
      end else begin
         unique case (opcode)
            OP_RTYPE: begin
               ctrl.dst_rd = 1'b1;
               ctrl.reg_we = 1'b1;
               case (funct)
                  FN_ADD:  ctrl.alu_op = ALU_ADD;
                  FN_SUB:  ctrl.alu_op = ALU_SUB;
                  FN_SLL:  ctrl.alu_op = ALU_SLL;
                  FN_SRL:  ctrl.alu_op = ALU_SRL;
                  FN_SLT:  ctrl.alu_op = ALU_SLT;
                  default: ctrl.reg_we = 1'b0;
               endcase
            end
            OP_ADDI: begin
               ctrl.b_imm  = 1'b1;
               ctrl.reg_we = 1'b1;
            end
            OP_LW: begin
               ctrl.b_imm  = 1'b1;
               ctrl.mem_rd = 1'b1;
               ctrl.reg_we = 1'b1;
            end
            OP_SW: begin
               ctrl.b_imm  = 1'b1;
               ctrl.mem_wr = 1'b1;
            end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_BNE:  ctrl.br_ne = 1'b1;
            default: ctrl = ctrl;
         endcase
      end
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int DW          = 32,
   parameter int SHIFT_STAGE = 1,
   localparam int SHW        = $clog2(DW)
) (
   input  alu_op_e        op,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  b,
   input  logic [SHW-1:0] amt,
   output logic [DW-1:0]  y,
   output logic           zero_eq
);

   logic [DW-1:0] shl;
   logic [DW-1:0] shr;

   generate
      if (SHIFT_STAGE != 0) begin : g_staged
         logic [DW-1:0] lst [SHW+1];
         logic [DW-1:0] rst [SHW+1];
         assign lst[0] = b;
         assign rst[0] = b;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            assign lst[s+1] = amt[s] ? (lst[s] << (1 << s)) : lst[s];
            assign rst[s+1] = amt[s] ? (rst[s] >> (1 << s)) : rst[s];
         end
         assign shl = lst[SHW];
         assign shr = rst[SHW];
      end else begin : g_operator
         assign shl = b << amt;
         assign shr = b >> amt;
      end
   endgenerate

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_SLL: y = shl;
         ALU_SRL: y = shr;
         ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
         default: y = '0;
      endcase
   end

   assign zero_eq = (a == b);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 32,
   localparam int SW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] wsel,
   input  logic [DW-1:0] wdata,
   input  logic [SW-1:0] asel,
   input  logic [SW-1:0] bsel,
   input  logic [SW-1:0] dsel,
   output logic [DW-1:0] adata,
   output logic [DW-1:0] bdata,
   output logic [DW-1:0] ddata
);

   logic [DW-1:0] regs_q [1:NREG-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
      end else if (we && wsel != '0) begin
         regs_q[wsel] <= wdata;
      end
   end

   assign adata = (asel == '0) ? '0 : regs_q[asel];
   assign bdata = (bsel == '0) ? '0 : regs_q[bsel];
   assign ddata = (dsel == '0) ? '0 : regs_q[dsel];

endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
   parameter int DW    = 32,
   parameter int WORDS = 256,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] iaddr,
   output logic [DW-1:0] idata,
   input  logic [AW-1:0] daddr,
   output logic [DW-1:0] ddata
);

   logic [DW-1:0] words_q [WORDS];

   always_ff @(posedge clk) begin
      if (we) words_q[waddr] <= wdata;
   end

   assign idata = words_q[iaddr];
   assign ddata = words_q[daddr];

endmodule

// File: rtl/mips_sc_core.sv
module mips_sc_core
   import sc_pkg::*;
#(
   parameter int DW          = 32,
   parameter int CW          = 32,
   parameter int NREG        = 32,
   parameter int MEM_BYTES   = 1024,
   parameter int TEXT_BASE   = 32'h200,
   parameter int SHIFT_STAGE = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ld_we,
   input  logic [$clog2(MEM_BYTES/4)-1:0] ld_addr,
   input  logic [31:0]                    ld_data,
   input  logic [$clog2(NREG)-1:0]        dbg_sel,
   output logic [DW-1:0]                  dbg_data,
   output logic [DW-1:0]                  pc,
   output logic [CW-1:0]                  cycle_cnt,
   output logic                           done
);

   localparam int WORDS = MEM_BYTES / 4;
   localparam int IW    = $clog2(WORDS);
   localparam int SW    = $clog2(NREG);

   generate
      if (DW != 32) begin : g_bad_dw
         $error("mips_sc_core: instruction fields need DW of 32");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("mips_sc_core: 5-bit register fields need NREG of 32");
      end
      if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || MEM_BYTES < 8) begin : g_bad_mem
         $error("mips_sc_core: MEM_BYTES must be a power of two");
      end
      if (TEXT_BASE >= MEM_BYTES || (TEXT_BASE % 4) != 0) begin : g_bad_base
         $error("mips_sc_core: TEXT_BASE must be word aligned inside memory");
      end
   endgenerate

   ctrl_t          ctrl;
   logic [31:0]    instr;
   logic [4:0]     f_rs, f_rt, f_rd, f_sh;
   logic [DW-1:0]  imm_sx;
   logic [DW-1:0]  rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_data;
   logic           eq;
   logic           run;
   logic           taken;
   logic [DW-1:0]  pc_plus4, br_target, pc_next;
   logic           mem_we;
   logic [IW-1:0]  mem_waddr;
   logic [DW-1:0]  mem_wdata;

   assign run = !done;

   sc_mem #(.DW(DW), .WORDS(WORDS)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .iaddr (pc[IW+1:2]),
      .idata (instr),
      .daddr (alu_y[IW+1:2]),
      .ddata (mem_rdata)
   );

   assign mem_we    = ld_we | (ctrl.mem_wr & run & rst_n);
   assign mem_waddr = ld_we ? ld_addr : alu_y[IW+1:2];
   assign mem_wdata = ld_we ? ld_data : rt_val;

   sc_decode #(.DW(DW)) u_dec (
      .instr  (instr),
      .ctrl   (ctrl),
      .rs     (f_rs),
      .rt     (f_rt),
      .rd     (f_rd),
      .shamt  (f_sh),
      .imm_sx (imm_sx)
   );

   sc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctrl.reg_we & run),
      .wsel  (ctrl.dst_rd ? f_rd : f_rt),
      .wdata (wb_data),
      .asel  (f_rs),
      .bsel  (f_rt),
      .dsel  (dbg_sel),
      .adata (rs_val),
      .bdata (rt_val),
      .ddata (dbg_data)
   );

   assign alu_b = ctrl.b_imm ? imm_sx : rt_val;

   sc_alu #(.DW(DW), .SHIFT_STAGE(SHIFT_STAGE)) u_alu (
      .op      (ctrl.alu_op),
      .a       (rs_val),
      .b       (alu_b),
      .amt     (f_sh[SW-1:0]),
      .y       (alu_y),
      .zero_eq (eq)
   );

   assign wb_data   = ctrl.mem_rd ? mem_rdata : alu_y;
   assign pc_plus4  = pc + DW'(4);
   assign br_target = pc_plus4 + {imm_sx[DW-3:0], 2'b00};
   assign taken     = (ctrl.br_eq & eq) | (ctrl.br_ne & ~eq);
   assign pc_next   = taken ? br_target : pc_plus4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc        <= DW'(TEXT_BASE);
         cycle_cnt <= '0;
         done      <= 1'b0;
      end else if (run) begin
         cycle_cnt <= cycle_cnt + CW'(1);
         if (ctrl.halt) done <= 1'b1;
         else           pc   <= pc_next;
      end
   end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
   parameter int DW        = 32,
   parameter int CW        = 32,
   parameter int SW        = 5,
   parameter int MEM_BYTES = 1024,
   parameter int TEXT_BASE = 32'h200
) (
   input logic          clk,
   input logic          rst_n,
   input logic [SW-1:0] dbg_sel,
   input logic [DW-1:0] dbg_data,
   input logic [DW-1:0] pc,
   input logic [CW-1:0] cycle_cnt,
   input logic          done
);

   // R1: state seen on the first edge after reset release
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pc == DW'(TEXT_BASE) && cycle_cnt == '0 && !done));

   // R7: the PC never leaves the text region and stays word aligned
   a_r7_pc_in_text: assert property (@(posedge clk) disable iff (!rst_n)
      (pc >= DW'(TEXT_BASE) && pc < DW'(MEM_BYTES) && pc[1:0] == 2'b00));

   // R8: register 0 reads zero
   a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_sel == '0) |-> (dbg_data == '0));

   // R9: done is sticky
   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R9: the PC is frozen after halt
   a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(pc));

   // R10: one count per executed word
   a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (cycle_cnt == $past(cycle_cnt) + CW'(1)));

   // R10: the count stops after halt
   a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(cycle_cnt));

endmodule

bind mips_sc_core sc_core_chk #(
   .DW(DW), .CW(CW), .SW($clog2(NREG)), .MEM_BYTES(MEM_BYTES), .TEXT_BASE(TEXT_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dbg_sel   (dbg_sel),
   .dbg_data  (dbg_data),
   .pc        (pc),
   .cycle_cnt (cycle_cnt),
   .done      (done)
);

// File: tb/mips_sc_core_tb.sv
`timescale 1ns/1ps
module mips_sc_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_we = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [4:0]  dbg_sel = '0;
   logic [31:0] dbg_data, pc, cycle_cnt;
   logic        done;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mips_sc_core u_dut (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc(pc), .cycle_cnt(cycle_cnt), .done(done)
   );

   // Expected registers after the main program: {req number, register, value}
   localparam int NV = 19;
   localparam logic [40:0] VEC [NV] = '{
      {4'd5,  5'd1,  32'h0000_0008},  // R5 addi positive
      {4'd6,  5'd2,  32'h0000_0001},  // R6 lw offset 0
      {4'd6,  5'd3,  32'h0000_0002},  // R6 lw offset 4
      {4'd2,  5'd4,  32'h0000_0003},  // R2 add
      {4'd2,  5'd5,  32'hFFFF_FFFF},  // R2 sub negative
      {4'd3,  5'd6,  32'h0000_0040},  // R3 sll by 5
      {4'd3,  5'd7,  32'h0000_000F},  // R3 srl logical by 28
      {4'd4,  5'd8,  32'h0000_0001},  // R4 slt -1 < 1
      {4'd4,  5'd9,  32'h0000_0000},  // R4 slt 1 < -1 false
      {4'd5,  5'd10, 32'hFFFF_FFFD},  // R5 addi negative immediate
      {4'd6,  5'd11, 32'h7FFF_FFFF},  // R6 lw offset 8
      {4'd2,  5'd12, 32'h8000_0000},  // R2 add wraps
      {4'd6,  5'd13, 32'h0000_0003},  // R6 sw/lw negative offset
      {4'd8,  5'd0,  32'h0000_0000},  // R8 write to $0 discarded
      {4'd8,  5'd14, 32'h0000_0001},  // R8 $0 reads zero as operand
      {4'd7,  5'd15, 32'h0000_0001},  // R7 not-taken executes, taken skips
      {4'd7,  5'd16, 32'h0000_0000},  // R7 backward loop ends at zero
      {4'd7,  5'd17, 32'h0000_0003},  // R7 backward loop ran three times
      {4'd9,  5'd18, 32'h0000_0000}   // R9 word after halt not executed
   };

   function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [4:0] sh,
                                         input logic [5:0] fn);
      return {6'h00, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic ld(input int idx, input logic [31:0] w);
      @(negedge clk);
      ld_we   = 1'b1;
      ld_addr = idx[7:0];
      ld_data = w;
      @(negedge clk);
      ld_we   = 1'b0;
   endtask

   task automatic rd_reg(input logic [4:0] r, output logic [31:0] v);
      dbg_sel = r;
      #1;
      v = dbg_data;
   endtask

   task automatic run_to_done(input int limit);
      int n = 0;
      while (!done && n < limit) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9: halt not reached, actual done %b expected 1", done);
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      // data words: byte 8 -> 1, byte 12 -> 2, byte 16 -> 0x7FFFFFFF
      ld(2, 32'd1);
      ld(3, 32'd2);
      ld(4, 32'h7FFF_FFFF);
      ld(128, enc_i(6'h08, 5'd0, 5'd1, 16'd8));        // addi $1,$0,8
      ld(129, enc_i(6'h23, 5'd1, 5'd2, 16'd0));        // lw $2,0($1)
      ld(130, enc_i(6'h23, 5'd1, 5'd3, 16'd4));        // lw $3,4($1)
      ld(131, enc_r(5'd2, 5'd3, 5'd4, 5'd0, 6'h20));   // add $4
      ld(132, enc_r(5'd2, 5'd3, 5'd5, 5'd0, 6'h22));   // sub $5
      ld(133, enc_r(5'd0, 5'd3, 5'd6, 5'd5, 6'h00));   // sll $6,$3,5
      ld(134, enc_r(5'd0, 5'd5, 5'd7, 5'd28, 6'h02));  // srl $7,$5,28
      ld(135, enc_r(5'd5, 5'd2, 5'd8, 5'd0, 6'h2A));   // slt $8,$5,$2
      ld(136, enc_r(5'd2, 5'd5, 5'd9, 5'd0, 6'h2A));   // slt $9,$2,$5
      ld(137, enc_i(6'h08, 5'd0, 5'd10, 16'hFFFD));    // addi $10,$0,-3
      ld(138, enc_i(6'h23, 5'd1, 5'd11, 16'd8));       // lw $11,8($1)
      ld(139, enc_r(5'd11, 5'd2, 5'd12, 5'd0, 6'h20)); // add $12 wraps
      ld(140, enc_i(6'h2B, 5'd1, 5'd4, 16'hFFFC));     // sw $4,-4($1)
      ld(141, enc_i(6'h23, 5'd1, 5'd13, 16'hFFFC));    // lw $13,-4($1)
      ld(142, enc_i(6'h08, 5'd0, 5'd0, 16'd5));        // addi $0,$0,5
      ld(143, enc_r(5'd0, 5'd2, 5'd14, 5'd0, 6'h20));  // add $14,$0,$2
      ld(144, enc_i(6'h04, 5'd2, 5'd3, 16'd1));        // beq not taken
      ld(145, enc_i(6'h08, 5'd0, 5'd15, 16'd1));       // addi $15,$0,1
      ld(146, enc_i(6'h05, 5'd2, 5'd3, 16'd1));        // bne taken
      ld(147, enc_i(6'h08, 5'd15, 5'd15, 16'd100));    // skipped
      ld(148, enc_i(6'h04, 5'd2, 5'd2, 16'd2));        // beq taken
      ld(149, enc_i(6'h08, 5'd15, 5'd15, 16'd100));    // skipped
      ld(150, enc_i(6'h08, 5'd15, 5'd15, 16'd100));    // skipped
      ld(151, enc_i(6'h08, 5'd0, 5'd16, 16'd3));       // addi $16,$0,3
      ld(152, enc_i(6'h08, 5'd17, 5'd17, 16'd1));      // loop: $17++
      ld(153, enc_i(6'h08, 5'd16, 5'd16, 16'hFFFF));   // $16--
      ld(154, enc_i(6'h05, 5'd16, 5'd0, 16'hFFFD));    // bne back to loop
      ld(155, enc_i(6'h05, 5'd2, 5'd2, 16'd5));        // bne not taken
      ld(156, 32'h0000_000C);                          // halt
      ld(157, enc_i(6'h08, 5'd0, 5'd18, 16'd7));       // must not execute

      // R1: reset state
      #1;
      chk("R1 pc", pc, 32'h200);
      chk("R1 cycle_cnt", cycle_cnt, 32'd0);
      chk("R1 done", {31'd0, done}, 32'd0);
      rd_reg(5'd5, v);
      chk("R1 reg5", v, 32'd0);

      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 pc after one word", pc, 32'h204);
      chk("R10 count after one word", cycle_cnt, 32'd1);

      run_to_done(1000);
      chk("R9 done", {31'd0, done}, 32'd1);
      chk("R9 pc at halt", pc, 32'h270);
      chk("R10 words executed", cycle_cnt, 32'd32);

      for (int i = 0; i < NV; i++) begin
         rd_reg(VEC[i][36:32], v);
         checks++;
         if (v !== VEC[i][31:0]) begin
            errors++;
            $display("FAIL R%0d: reg %0d actual %h expected %h",
                     VEC[i][40:37], VEC[i][36:32], v, VEC[i][31:0]);
         end
      end

      // R9: frozen after halt
      repeat (5) @(negedge clk);
      chk("R9 pc frozen", pc, 32'h270);
      chk("R9 count frozen", cycle_cnt, 32'd32);
      chk("R9 done held", {31'd0, done}, 32'd1);

      // R1 / R11: reset again, memory kept
      rst_n = 1'b0;
      #1;
      chk("R1 pc after second reset", pc, 32'h200);
      chk("R1 done cleared", {31'd0, done}, 32'd0);
      rd_reg(5'd4, v);
      chk("R1 reg4 cleared", v, 32'd0);
      ld(128, enc_i(6'h23, 5'd0, 5'd1, 16'd4));        // lw $1,4($0)
      ld(129, 32'h0000_000C);                          // halt
      @(negedge clk);
      rst_n = 1'b1;
      run_to_done(100);
      rd_reg(5'd1, v);
      chk("R11 stored word kept", v, 32'd3);
      chk("R10 two words", cycle_cnt, 32'd2);
      chk("R9 pc at short halt", pc, 32'h204);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule